// File: doc/BRIEF.md
# CPU Low-Power Mode Sequencer

This block steps one CPU core through the entry into a low-power mode and back out again. The core raises `core_sleep` to signal that it wants to sleep. If a non-run target mode has been programmed, the block walks through the sleep half of a sixteen-entry step list. Each step either raises a request to its own local timing unit and waits for that unit's completion pulse, or hands the work to an external setpoint controller or standby controller through a request/acknowledge pair. When the last sleep step finishes, the core sits in the target mode. An enabled wakeup source then starts the mirror-image wakeup half of the list, and the block returns to run mode.

Step indices 0 to 7 belong to sleep and 8 to 15 belong to wakeup. The sleep steps are state save (0), clock gating (1), PLL (2), isolation (3), reset (4), power (5), setpoint (6) and standby (7). The wakeup steps are standby (8), setpoint (9), power (10), reset (11), isolation (12), PLL (13), clock gating (14) and state restore (15). Steps 6 to 9 are delegated to the external controllers; the other twelve are local. Configuration arrives on plain register-style pins. Status comes out on plain pins: the current and previous mode and two busy flags. The request/acknowledge pairs are level handshakes: a request stays high with its qualifiers stable until the acknowledge is sampled high. There is no back-pressure beyond this.

Top module: `cpu_lp_sequencer`

## Requirements
- R1: After reset, `mode_cur` and `mode_prev` are 0 (run), both busy flags are 0, `core_hold` is 0, and no request output is high.
- R2: The sleep steps run in ascending index order 0 to 7. Local step index i in 0..5 uses `local_req[i]`/`local_done[i]`. Step 6 is `sp_req` during sleep. Step 7 is `stby_req` with `stby_enter`=1. A local step finishes in the cycle its `local_done` bit is high while it is requested, and the next step's request appears in the following cycle.
- R3: The wakeup steps run in ascending index order 8 to 15. Step 8 is `stby_req` with `stby_enter`=0. Step 9 is `sp_req` during wakeup. Local step index i in 10..15 uses `local_req[i-4]`/`local_done[i-4]`.
- R4: A local step whose bit in `cfg_step_en` (the same slot number as its `local_req` bit) is 0 is skipped, and its request never rises.
- R5: The target mode is 2 bits (0 run, 1 wait, 2 stop, 3 suspend), written with `cfg_mode_wr`. The target is consumed (reset to run) when a sleep sequence starts. `core_sleep` with a run target starts no step and sets no busy flag.
- R6: When the last sleep step finishes, `mode_cur` becomes the target and `mode_prev` takes the old `mode_cur`. When the last wakeup step finishes, `mode_cur` becomes 0 and `mode_prev` takes the mode that was left.
- R7: `sleep_busy` is high exactly while sleep steps run, and `wake_busy` is high exactly while wakeup steps run. The two are never high together.
- R8: A wakeup event is any `irq_in[n]` with `cfg_irq_en[n]`=1, `evt_wake` with `cfg_nirq_mask[0]`=0, or `dbg_wake` with `cfg_nirq_mask[1]`=0. A mask bit of 1 disables its non-IRQ source. Disabled sources do not wake the core.
- R9: A wakeup event seen while sleep steps are still running is latched. The wakeup sequence then starts only after step 7 finishes, with no further event needed.
- R10: During step 6, `sp_target` equals `cfg_sp_sleep`. During step 9, it equals `cfg_sp_wake` when `cfg_sp_wake_prev`=0, or the value of `sys_sp_current` captured at sleep start when it is 1. `sp_target` stays stable while `sp_req` is high.
- R11: The standby step is done on `stby_ack`. `stby_enter` is 1 during step 7 and 0 during step 8.
- R12: When `cfg_hold_en` is 1 at sleep start, `core_hold` is high from the first sleep step until the last wakeup step finishes. When it is 0, `core_hold` stays low.
- R13: At most one of `local_req`, `sp_req` and `stby_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_wr | input | 1 | Write strobe for the target mode |
| cfg_mode | input | 2 | Target mode value (0 run, 1 wait, 2 stop, 3 suspend) |
| cfg_step_en | input | 12 | Enable per local step slot |
| cfg_hold_en | input | 1 | Hold the core asleep until wakeup ends |
| cfg_irq_en | input | NIRQ | Per-IRQ wakeup enable |
| cfg_nirq_mask | input | 2 | Disable bits: [0] event, [1] debug |
| cfg_sp_sleep | input | SPW | Setpoint requested during sleep |
| cfg_sp_wake | input | SPW | Programmed wakeup setpoint |
| cfg_sp_wake_prev | input | 1 | 1: on wakeup, request the setpoint captured at sleep start |
| sys_sp_current | input | SPW | Setpoint the system is in now |
| core_sleep | input | 1 | Core signals sleep |
| irq_in | input | NIRQ | Interrupt lines |
| evt_wake | input | 1 | Event wakeup source |
| dbg_wake | input | 1 | Debug wakeup source |
| local_req | output | 12 | Request per local step slot |
| local_done | input | 12 | Completion per local step slot |
| sp_req | output | 1 | Setpoint controller request |
| sp_target | output | SPW | Requested setpoint |
| sp_ack | input | 1 | Setpoint controller acknowledge |
| stby_req | output | 1 | Standby controller request |
| stby_enter | output | 1 | 1 enter standby, 0 exit standby |
| stby_ack | input | 1 | Standby controller acknowledge |
| core_hold | output | 1 | Keeps the core asleep |
| mode_cur | output | 2 | Current CPU mode |
| mode_prev | output | 2 | Previous CPU mode |
| sleep_busy | output | 1 | Sleep steps in progress |
| wake_busy | output | 1 | Wakeup steps in progress |

## Verification
The case that needs care is a wakeup source firing while the sleep half is still stepping, since arrival and completion of sleep then overlap. The bench provokes it by pulsing an enabled IRQ for one cycle during step 2 and keeping it low afterwards. The run passes only if the logged requests show all eight sleep steps in order, followed by all eight wakeup steps with no second event. A related overlap checks that the hold is released together with the final wakeup step and not before it.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SLEEP  = 2'd1,
    SQ_ASLEEP = 2'd2,
    SQ_WAKE   = 2'd3
  } sq_state_e;

  localparam int unsigned NLOCAL = 12;
  localparam logic [1:0] MODE_RUN = 2'd0;

  localparam logic [3:0] IDX_SP_DOWN   = 4'd6;
  localparam logic [3:0] IDX_SB_IN     = 4'd7;
  localparam logic [3:0] IDX_SB_OUT    = 4'd8;
  localparam logic [3:0] IDX_SP_UP     = 4'd9;
  localparam logic [3:0] IDX_SLEEP_END = 4'd7;
  localparam logic [3:0] IDX_WAKE_BEG  = 4'd8;
  localparam logic [3:0] IDX_WAKE_END  = 4'd15;

  // Steps outside 6..9 run on a local timing unit.
  function automatic logic is_local(input logic [3:0] idx);
    return (idx < IDX_SP_DOWN) || (idx > IDX_SP_UP);
  endfunction

  // Local slot number: sleep steps keep their index, wakeup steps shift down by four.
  function automatic logic [3:0] local_slot(input logic [3:0] idx);
    return (idx < IDX_SP_DOWN) ? idx : idx - 4'd4;
  endfunction

endpackage

// File: rtl/lpseq_wake_detect.sv
module lpseq_wake_detect #(
  parameter int unsigned NIRQ = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_in,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            evt_wake,
  input  logic            dbg_wake,
  input  logic [1:0]      nirq_mask,
  output logic            wake_q
);

  logic irq_hit;
  logic nirq_hit;

  // Wide reduction is registered to keep it out of the sequencing path.
  assign irq_hit  = |(irq_in & irq_en);
  assign nirq_hit = (evt_wake & ~nirq_mask[0]) | (dbg_wake & ~nirq_mask[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= irq_hit | nirq_hit;
  end

endmodule

// File: rtl/lpseq_req_decode.sv
module lpseq_req_decode
  import lpseq_pkg::*;
(
  input  sq_state_e         st,
  input  logic [3:0]        idx,
  input  logic [NLOCAL-1:0] step_en,
  input  logic [NLOCAL-1:0] local_done,
  input  logic              sp_ack,
  input  logic              stby_ack,
  output logic [NLOCAL-1:0] local_req,
  output logic              sp_req,
  output logic              stby_req,
  output logic              stby_enter,
  output logic              step_fin
);

  logic       active;
  logic       loc;
  logic [3:0] slot;
  logic       slot_en;
  logic       slot_done;

  assign active    = (st == SQ_SLEEP) || (st == SQ_WAKE);
  assign loc       = is_local(idx);
  assign slot      = local_slot(idx);
  assign slot_en   = step_en[slot];
  assign slot_done = local_done[slot];

  for (genvar k = 0; k < NLOCAL; k++) begin : g_req
    assign local_req[k] = active && loc && (slot == 4'(k)) && step_en[k];
  end

  assign sp_req     = active && ((idx == IDX_SP_DOWN) || (idx == IDX_SP_UP));
  assign stby_req   = active && ((idx == IDX_SB_IN) || (idx == IDX_SB_OUT));
  assign stby_enter = (idx == IDX_SB_IN);

  always_comb begin
    if (!active)      step_fin = 1'b0;
    else if (loc)     step_fin = !slot_en || slot_done;
    else if (sp_req)  step_fin = sp_ack;
    else              step_fin = stby_ack;
  end

endmodule

// File: rtl/lpseq_step_engine.sv
module lpseq_step_engine
  import lpseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wake_go,
  input  logic       step_fin,
  output sq_state_e  st,
  output logic [3:0] idx,
  output logic       sleep_last,
  output logic       wake_last
);

  assign sleep_last = (st == SQ_SLEEP) && (idx == IDX_SLEEP_END) && step_fin;
  assign wake_last  = (st == SQ_WAKE)  && (idx == IDX_WAKE_END)  && step_fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      idx <= 4'd0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) begin
          st  <= SQ_SLEEP;
          idx <= 4'd0;
        end
        SQ_SLEEP: if (step_fin) begin
          if (idx == IDX_SLEEP_END) st <= SQ_ASLEEP;
          else                      idx <= idx + 4'd1;
        end
        SQ_ASLEEP: if (wake_go) begin
          st  <= SQ_WAKE;
          idx <= IDX_WAKE_BEG;
        end
        SQ_WAKE: if (step_fin) begin
          if (idx == IDX_WAKE_END) begin
            st  <= SQ_IDLE;
            idx <= 4'd0;
          end else begin
            idx <= idx + 4'd1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cpu_lp_sequencer.sv
module cpu_lp_sequencer
  import lpseq_pkg::*;
#(
  parameter int unsigned NIRQ = 256,
  parameter int unsigned SPW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_mode_wr,
  input  logic [1:0]      cfg_mode,
  input  logic [11:0]     cfg_step_en,
  input  logic            cfg_hold_en,
  input  logic [NIRQ-1:0] cfg_irq_en,
  input  logic [1:0]      cfg_nirq_mask,
  input  logic [SPW-1:0]  cfg_sp_sleep,
  input  logic [SPW-1:0]  cfg_sp_wake,
  input  logic            cfg_sp_wake_prev,
  input  logic [SPW-1:0]  sys_sp_current,
  input  logic            core_sleep,
  input  logic [NIRQ-1:0] irq_in,
  input  logic            evt_wake,
  input  logic            dbg_wake,
  output logic [11:0]     local_req,
  input  logic [11:0]     local_done,
  output logic            sp_req,
  output logic [SPW-1:0]  sp_target,
  input  logic            sp_ack,
  output logic            stby_req,
  output logic            stby_enter,
  input  logic            stby_ack,
  output logic            core_hold,
  output logic [1:0]      mode_cur,
  output logic [1:0]      mode_prev,
  output logic            sleep_busy,
  output logic            wake_busy
);

  sq_state_e      st;
  logic [3:0]     idx;
  logic           step_fin;
  logic           sleep_last;
  logic           wake_last;
  logic           wake_q;
  logic           start;
  logic           wake_go;
  logic [1:0]     tgt_q;
  logic [1:0]     sleep_mode_q;
  logic [SPW-1:0] sp_saved_q;
  logic           pend_q;

  lpseq_wake_detect #(.NIRQ(NIRQ)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .irq_en    (cfg_irq_en),
    .evt_wake  (evt_wake),
    .dbg_wake  (dbg_wake),
    .nirq_mask (cfg_nirq_mask),
    .wake_q    (wake_q)
  );

  lpseq_req_decode u_dec (
    .st         (st),
    .idx        (idx),
    .step_en    (cfg_step_en),
    .local_done (local_done),
    .sp_ack     (sp_ack),
    .stby_ack   (stby_ack),
    .local_req  (local_req),
    .sp_req     (sp_req),
    .stby_req   (stby_req),
    .stby_enter (stby_enter),
    .step_fin   (step_fin)
  );

  lpseq_step_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .wake_go    (wake_go),
    .step_fin   (step_fin),
    .st         (st),
    .idx        (idx),
    .sleep_last (sleep_last),
    .wake_last  (wake_last)
  );

  assign start   = (st == SQ_IDLE) && core_sleep && (tgt_q != MODE_RUN);
  assign wake_go = wake_q || pend_q;

  assign sleep_busy = (st == SQ_SLEEP);
  assign wake_busy  = (st == SQ_WAKE);
  assign sp_target  = (st == SQ_SLEEP)  ? cfg_sp_sleep :
                      cfg_sp_wake_prev ? sp_saved_q   : cfg_sp_wake;

  // Target register: a sleep start consumes it before any new write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tgt_q <= MODE_RUN;
    else if (start)       tgt_q <= MODE_RUN;
    else if (cfg_mode_wr) tgt_q <= cfg_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_mode_q <= MODE_RUN;
      sp_saved_q   <= '0;
      core_hold    <= 1'b0;
    end else if (start) begin
      sleep_mode_q <= tgt_q;
      sp_saved_q   <= sys_sp_current;
      core_hold    <= cfg_hold_en;
    end else if (wake_last) begin
      core_hold    <= 1'b0;
    end
  end

  // Wakeup seen mid-sleep is kept until the core is fully asleep.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pend_q <= 1'b0;
    else if (st == SQ_SLEEP && wake_q)    pend_q <= 1'b1;
    else if (st == SQ_ASLEEP)             pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cur  <= MODE_RUN;
      mode_prev <= MODE_RUN;
    end else if (sleep_last) begin
      mode_prev <= mode_cur;
      mode_cur  <= sleep_mode_q;
    end else if (wake_last) begin
      mode_prev <= mode_cur;
      mode_cur  <= MODE_RUN;
    end
  end

endmodule

// File: rtl/lpseq_chk.sv
module lpseq_chk #(
  parameter int unsigned SPW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [11:0]    local_req,
  input logic           sp_req,
  input logic [SPW-1:0] sp_target,
  input logic           stby_req,
  input logic           stby_enter,
  input logic           core_hold,
  input logic [1:0]     mode_cur,
  input logic           sleep_busy,
  input logic           wake_busy
);

  // R13
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({local_req, sp_req, stby_req}));

  // R7
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_busy && wake_busy));

  // R5
  sleep_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_busy) |-> mode_cur == 2'd0);

  // R6
  wake_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_busy) |-> mode_cur != 2'd0);

  // R10
  sp_target_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_req && $past(sp_req)) |-> $stable(sp_target));

  // R11
  stby_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby_req |-> (stby_enter == sleep_busy));

  // R12
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_hold) |-> $past(wake_busy));

endmodule

bind cpu_lp_sequencer lpseq_chk #(.SPW(SPW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .local_req  (local_req),
  .sp_req     (sp_req),
  .sp_target  (sp_target),
  .stby_req   (stby_req),
  .stby_enter (stby_enter),
  .core_hold  (core_hold),
  .mode_cur   (mode_cur),
  .sleep_busy (sleep_busy),
  .wake_busy  (wake_busy)
);

// File: tb/tb_cpu_lp_sequencer.sv
module tb_cpu_lp_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 256;
  localparam int SPW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mode_wr = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [11:0] cfg_step_en = 12'hFFF;
  logic cfg_hold_en = 1'b0;
  logic [NIRQ-1:0] cfg_irq_en = '0;
  logic [1:0] cfg_nirq_mask = 2'b11;
  logic [SPW-1:0] cfg_sp_sleep = 4'd2;
  logic [SPW-1:0] cfg_sp_wake = 4'd12;
  logic cfg_sp_wake_prev = 1'b0;
  logic [SPW-1:0] sys_sp_current = 4'd5;
  logic core_sleep = 1'b0;
  logic [NIRQ-1:0] irq_in = '0;
  logic evt_wake = 1'b0, dbg_wake = 1'b0;
  logic [11:0] local_req, local_done;
  logic sp_req, sp_ack, stby_req, stby_enter, stby_ack;
  logic [SPW-1:0] sp_target;
  logic core_hold, sleep_busy, wake_busy;
  logic [1:0] mode_cur, mode_prev;

  int n_tests = 0;
  int n_fail = 0;

  cpu_lp_sequencer #(.NIRQ(NIRQ), .SPW(SPW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Timing-unit and controller models: one-cycle acknowledge pulses.
  always @(posedge clk) begin
    local_done <= local_req & ~local_done;
    sp_ack     <= sp_req & ~sp_ack;
    stby_ack   <= stby_req & ~stby_ack;
  end
  initial begin local_done = '0; sp_ack = 1'b0; stby_ack = 1'b0; end

  // Request monitor: logs each step index at its request's rising edge.
  logic [3:0] seq_log [0:63];
  int seq_n = 0;
  logic [11:0] lr_prev = '0;
  logic sp_prev = 1'b0, sb_prev = 1'b0;
  logic [SPW-1:0] sp_dn_seen = '0, sp_up_seen = '0;
  logic sb_in_dir = 1'b0, sb_out_dir = 1'b1;
  logic hold_dropped_early = 1'b0;

  always @(negedge clk) begin
    for (int k = 0; k < 12; k++)
      if (local_req[k] && !lr_prev[k] && seq_n < 64) begin
        seq_log[seq_n] = (k < 6) ? 4'(k) : 4'(k + 4);
        seq_n++;
      end
    if (sp_req && !sp_prev && seq_n < 64) begin
      seq_log[seq_n] = sleep_busy ? 4'd6 : 4'd9;
      seq_n++;
      if (sleep_busy) sp_dn_seen = sp_target; else sp_up_seen = sp_target;
    end
    if (stby_req && !sb_prev && seq_n < 64) begin
      seq_log[seq_n] = sleep_busy ? 4'd7 : 4'd8;
      seq_n++;
      if (sleep_busy) sb_in_dir = stby_enter; else sb_out_dir = stby_enter;
    end
    lr_prev = local_req; sp_prev = sp_req; sb_prev = stby_req;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Compare the log against the ascending list of steps set in exp_mask.
  task automatic check_seq(input string req, input logic [15:0] exp_mask);
    int j = 0;
    int bad = 0;
    for (int i = 0; i < 16; i++)
      if (exp_mask[i]) begin
        if (j >= seq_n || seq_log[j] != 4'(i)) bad++;
        j++;
      end
    if (j != seq_n) bad++;
    check(req, bad, 0);
  endtask

  task automatic clear_log();
    @(negedge clk);
    seq_n = 0;
  endtask

  task automatic set_target(input logic [1:0] m);
    @(negedge clk); cfg_mode = m; cfg_mode_wr = 1'b1;
    @(negedge clk); cfg_mode_wr = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); core_sleep = 1'b1;
    @(negedge clk); core_sleep = 1'b0;
  endtask

  task automatic wait_mode(input logic [1:0] m);
    for (int i = 0; i < 300; i++) begin
      if (mode_cur == m && !sleep_busy && !wake_busy) break;
      @(negedge clk);
    end
  endtask

  task automatic fire_irq(input int line);
    @(negedge clk); irq_in[line] = 1'b1;
    @(negedge clk); irq_in[line] = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 mode_cur", mode_cur, 0);
    check("R1 mode_prev", mode_prev, 0);
    check("R1 busy", {sleep_busy, wake_busy}, 0);
    check("R1 hold", core_hold, 0);
    check("R1 requests", {local_req, sp_req, stby_req}, 0);
  endtask

  task automatic t_run_target();
    int busy_seen = 0;
    clear_log();
    set_target(2'd0);
    pulse_sleep();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sleep_busy || wake_busy) busy_seen++;
    end
    check("R5 run target starts no step", seq_n, 0);
    check("R5 run target no busy", busy_seen, 0);
  endtask

  task automatic t_full_cycle();
    clear_log();
    cfg_hold_en = 1'b1;
    cfg_irq_en[200] = 1'b1;
    set_target(2'd2);
    pulse_sleep();
    check("R7 sleep_busy in first step", sleep_busy, 1);
    check("R12 hold raised at sleep start", core_hold, 1);
    wait_mode(2'd2);
    check_seq("R2 sleep order", 16'h00FF);
    check("R6 mode_cur after sleep", mode_cur, 2);
    check("R6 mode_prev after sleep", mode_prev, 0);
    check("R10 sleep setpoint", sp_dn_seen, 2);
    check("R11 standby enter", sb_in_dir, 1);
    check("R12 hold while asleep", core_hold, 1);
    fire_irq(200);
    @(negedge clk);
    check("R7 wake_busy", wake_busy, 1);
    wait_mode(2'd0);
    check_seq("R3 full sequence", 16'hFFFF);
    check("R6 mode_prev after wake", mode_prev, 2);
    check("R10 wake setpoint programmed", sp_up_seen, 12);
    check("R11 standby exit", sb_out_dir, 0);
    check("R12 hold released", core_hold, 0);
    cfg_hold_en = 1'b0;
  endtask

  task automatic t_consumed();
    clear_log();
    pulse_sleep();
    repeat (20) @(negedge clk);
    check("R5 target consumed", seq_n, 0);
    check("R5 mode stays run", mode_cur, 0);
  endtask

  task automatic t_skip();
    clear_log();
    cfg_step_en = 12'b1010_1111_0101; // skip slots 1,3 (steps 1,3) and 8,10 (steps 12,14)
    set_target(2'd1);
    pulse_sleep();
    check("R12 no hold when disabled", core_hold, 0);
    wait_mode(2'd1);
    fire_irq(200);
    @(negedge clk);
    wait_mode(2'd0);
    check_seq("R4 disabled steps skipped", 16'hAFF5);
    cfg_step_en = 12'hFFF;
  endtask

  task automatic t_masks();
    clear_log();
    set_target(2'd3);
    pulse_sleep();
    wait_mode(2'd3);
    cfg_nirq_mask = 2'b01;
    @(negedge clk); evt_wake = 1'b1; irq_in[5] = 1'b1;
    @(negedge clk); evt_wake = 1'b0; irq_in[5] = 1'b0;
    repeat (20) @(negedge clk);
    check("R8 masked sources ignored", mode_cur, 3);
    check("R8 no wake busy", wake_busy, 0);
    @(negedge clk); dbg_wake = 1'b1;
    @(negedge clk); dbg_wake = 1'b0;
    @(negedge clk);
    wait_mode(2'd0);
    check("R8 debug wakes", mode_prev, 3);
    cfg_nirq_mask = 2'b11;
  endtask

  task automatic t_latched();
    clear_log();
    cfg_sp_wake_prev = 1'b1;
    sys_sp_current = 4'd5;
    set_target(2'd2);
    pulse_sleep();
    sys_sp_current = 4'd9;
    for (int i = 0; i < 50; i++) begin
      if (seq_n >= 3) break;
      @(negedge clk);
    end
    fire_irq(200);
    check("R9 still sleeping after event", sleep_busy, 1);
    for (int i = 0; i < 300; i++) begin
      if (!sleep_busy && !wake_busy && mode_cur == 2'd0) break;
      @(negedge clk);
    end
    check_seq("R9 latched wake after full sleep", 16'hFFFF);
    check("R9 mode_prev", mode_prev, 2);
    check("R10 wake setpoint from sleep start", sp_up_seen, 5);
    cfg_sp_wake_prev = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_target();
    t_full_cycle();
    t_consumed();
    t_skip();
    t_masks();
    t_latched();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule